// File: doc/BRIEF.md
# Audio Sample-Rate Speed-Mode Detector

This block observes the three clocks of a serial audio input: the master clock, the bit clock and the left/right frame clock. It decides which speed class the stream belongs to. A free-running reference clock of known frequency, given by `REF_HZ`, times each frame period. The measured period is compared against three frame-rate windows. Single speed covers 8 to 54 kHz, double speed covers 84 to 108 kHz and quad speed covers 170 to 216 kHz. Any rate in the gaps between the windows, or outside all of them, is rejected. Each window bound carries a tolerance of one reference count.

In the same frame the block counts master-clock cycles. The class and this count are then held to a qualification rule: a result is reported as valid only after four frames in a row agree on both values. A separate lock output says whether the master-to-frame ratio belongs to the set allowed for the detected class. If any of the three clocks stops toggling, every result is cleared at once.

All three input clocks are asynchronous to the reference clock. Each clock passes through a two-flop synchronizer and a rising-edge detector. Each clock must therefore be slower than half the reference frequency.

Top module: `spd_mode_detect`

## Requirements
- R1: A stable frame period within the single-speed window (8 to 54 kHz) yields mode_o = 2'b01.
- R2: A stable frame period within the double-speed window (84 to 108 kHz) yields mode_o = 2'b10.
- R3: A stable frame period within the quad-speed window (170 to 216 kHz) yields mode_o = 2'b11.
- R4: A frame period in a gap between windows, or outside all windows, yields mode_o = 2'b00 with valid_o and lock_o both low.
- R5: If the master clock or the bit clock shows no rising edge for PRES_TMO reference cycles, mode_o, valid_o, lock_o and ratio_o all clear to zero. For the frame clock the limit is the longest single-speed period plus PRES_TMO.
- R6: ratio_o reports the number of master-clock rising edges between two consecutive frame-clock rising edges.
- R7: lock_o is high only while valid_o is high and ratio_o is in the allowed set for the mode: 256/384/512/768/1024 for single, 128/192/256/384/512 for double, 128/192/256 for quad.
- R8: valid_o rises only after four consecutive measured frames give the same nonzero mode and the same ratio. Nothing is measured for the first frame edge after reset or after a clock returns.
- R9: valid_o falls on the first measured frame whose mode or ratio differs from the previous frame.
- R10: Each window accepts periods of floor(REF_HZ/f_max) - 1 through floor(REF_HZ/f_min) + 1 reference cycles. One count below the lower bound is rejected.
- R11: After reset, mode_o = 2'b00, valid_o = 0, lock_o = 0 and ratio_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock of frequency REF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| frm_clk_i | input | 1 | Left/right frame clock (asynchronous) |
| bit_clk_i | input | 1 | Serial bit clock (asynchronous) |
| mst_clk_i | input | 1 | Master clock (asynchronous) |
| mode_o | output | 2 | Speed class: 00 none, 01 single, 10 double, 11 quad |
| valid_o | output | 1 | Mode and ratio qualified over four frames |
| ratio_o | output | RATIO_W | Master-clock cycles per frame |
| lock_o | output | 1 | Qualified and ratio allowed for the mode |

## Verification
The bench uses the default parameters. REF_HZ is 98,304,000, so the frame periods are a few hundred to a few thousand reference cycles and the master clock is 2 to 4 reference cycles. That makes every window, both gaps and the lower single-speed tolerance edge (1819 accepted, 1818 rejected) reachable in a short run. With PRES_TMO at 64, stopping the master clock or the bit clock shows the clearing within about a hundred cycles. The bench also switches ratio while keeping the same period, which exercises the drop of the valid flag on its own. Allowed and disallowed ratios in each class drive lock_o both ways.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_DOUBLE = 2'b10,
    MODE_QUAD   = 2'b11
  } spd_mode_e;

  // Master-to-frame ratios permitted in each speed class.
  function automatic logic ratio_allowed(spd_mode_e m, int unsigned r);
    case (m)
      MODE_SINGLE: return r inside {256, 384, 512, 768, 1024};
      MODE_DOUBLE: return r inside {128, 192, 256, 384, 512};
      MODE_QUAD:   return r inside {128, 192, 256};
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // Two flops for metastability, third flop for edge detection.
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R6: a rising-edge pulse never lasts two cycles
  a_r6_edge_single: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/spd_clk_watch.sv
module spd_clk_watch #(
  parameter int TMO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic present_o
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] idle_q;

  // Reset state counts as "missing" until the first edge arrives.
  always_ff @(posedge clk) begin
    if (rst)                      idle_q <= CW'(TMO);
    else if (edge_i)              idle_q <= '0;
    else if (idle_q != CW'(TMO))  idle_q <= idle_q + 1'b1;
  end

  assign present_o = (idle_q != CW'(TMO));

  // R5: idle counter saturates at the timeout
  a_r5_watch_bound: assert property (@(posedge clk) disable iff (rst)
    idle_q <= CW'(TMO));
  // R5: an edge always restores presence on the next cycle
  a_r5_edge_present: assert property (@(posedge clk) disable iff (rst)
    edge_i |=> present_o);

endmodule

// File: rtl/spd_frame_meter.sv
module spd_frame_meter #(
  parameter int PER_W   = 14,
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               frm_rise_i,
  input  logic               mst_rise_i,
  output logic               stb_o,
  output logic [PER_W-1:0]   period_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic               primed_q;
  logic [PER_W-1:0]   per_cnt_q;
  logic [RATIO_W-1:0] mst_cnt_q;
  logic [RATIO_W-1:0] mst_inc;

  // Saturating master-edge count including an edge in the current cycle.
  always_comb begin
    if (mst_rise_i && mst_cnt_q != '1) mst_inc = mst_cnt_q + 1'b1;
    else                               mst_inc = mst_cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      primed_q  <= 1'b0;
      per_cnt_q <= PER_W'(1);
      mst_cnt_q <= '0;
      stb_o     <= 1'b0;
      period_o  <= '0;
      ratio_o   <= '0;
    end else begin
      stb_o <= 1'b0;
      if (frm_rise_i) begin
        // The first edge only opens the measurement window.
        primed_q  <= 1'b1;
        stb_o     <= primed_q;
        period_o  <= per_cnt_q;
        ratio_o   <= mst_inc;
        per_cnt_q <= PER_W'(1);
        mst_cnt_q <= '0;
      end else begin
        if (per_cnt_q != '1) per_cnt_q <= per_cnt_q + 1'b1;
        mst_cnt_q <= mst_inc;
      end
    end
  end

  // R6: a measurement strobe is always caused by a frame edge one cycle earlier
  a_r6_stb_follows_frame: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> $past(frm_rise_i));

endmodule

// File: rtl/spd_window_class.sv
module spd_window_class
  import spd_pkg::*;
#(
  parameter int PER_W     = 14,
  parameter int REF_HZ    = 98_304_000,
  parameter int SS_MIN_HZ = 8_000,
  parameter int SS_MAX_HZ = 54_000,
  parameter int DS_MIN_HZ = 84_000,
  parameter int DS_MAX_HZ = 108_000,
  parameter int QS_MIN_HZ = 170_000,
  parameter int QS_MAX_HZ = 216_000
) (
  input  logic [PER_W-1:0] period_i,
  output spd_mode_e        mode_o
);
  logic [2:0] hit;

  for (genvar g = 0; g < 3; g++) begin : g_win
    localparam int FMAX = (g == 0) ? SS_MAX_HZ : (g == 1) ? DS_MAX_HZ : QS_MAX_HZ;
    localparam int FMIN = (g == 0) ? SS_MIN_HZ : (g == 1) ? DS_MIN_HZ : QS_MIN_HZ;
    localparam int LO   = REF_HZ / FMAX - 1;
    localparam int HI   = REF_HZ / FMIN + 1;
    assign hit[g] = (period_i >= PER_W'(LO)) && (period_i <= PER_W'(HI));
  end

  always_comb begin
    if (hit[0])      mode_o = MODE_SINGLE;
    else if (hit[1]) mode_o = MODE_DOUBLE;
    else if (hit[2]) mode_o = MODE_QUAD;
    else             mode_o = MODE_NONE;
  end

endmodule

// File: rtl/spd_mode_detect.sv
module spd_mode_detect
  import spd_pkg::*;
#(
  parameter int REF_HZ    = 98_304_000,
  parameter int SS_MIN_HZ = 8_000,
  parameter int SS_MAX_HZ = 54_000,
  parameter int DS_MIN_HZ = 84_000,
  parameter int DS_MAX_HZ = 108_000,
  parameter int QS_MIN_HZ = 170_000,
  parameter int QS_MAX_HZ = 216_000,
  parameter int PRES_TMO  = 64,
  parameter int STABLE_N  = 4,
  parameter int RATIO_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_clk_i,
  input  logic               bit_clk_i,
  input  logic               mst_clk_i,
  output logic [1:0]         mode_o,
  output logic               valid_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               lock_o
);
  localparam int FRM_TMO = REF_HZ / SS_MIN_HZ + 1 + PRES_TMO;
  localparam int PER_W   = $clog2(FRM_TMO + 1);
  localparam int RUN_W   = $clog2(STABLE_N);
  localparam int NCLK    = 3;

  // Index 0: frame clock, 1: bit clock, 2: master clock
  logic [NCLK-1:0] clk_in, rise, present;
  assign clk_in = {mst_clk_i, bit_clk_i, frm_clk_i};

  for (genvar i = 0; i < NCLK; i++) begin : g_clk
    spd_edge_sync u_sync (
      .clk(clk), .rst(rst), .async_i(clk_in[i]), .rise_o(rise[i])
    );
    if (i == 0) begin : g_frm
      spd_clk_watch #(.TMO(FRM_TMO)) u_watch (
        .clk(clk), .rst(rst), .edge_i(rise[i]), .present_o(present[i])
      );
    end else begin : g_fast
      spd_clk_watch #(.TMO(PRES_TMO)) u_watch (
        .clk(clk), .rst(rst), .edge_i(rise[i]), .present_o(present[i])
      );
    end
  end

  logic all_present;
  assign all_present = &present;

  logic               meas_stb;
  logic [PER_W-1:0]   meas_per;
  logic [RATIO_W-1:0] meas_ratio;

  spd_frame_meter #(.PER_W(PER_W), .RATIO_W(RATIO_W)) u_meter (
    .clk(clk), .rst(rst), .en_i(all_present),
    .frm_rise_i(rise[0]), .mst_rise_i(rise[2]),
    .stb_o(meas_stb), .period_o(meas_per), .ratio_o(meas_ratio)
  );

  spd_mode_e cls;

  spd_window_class #(
    .PER_W(PER_W), .REF_HZ(REF_HZ),
    .SS_MIN_HZ(SS_MIN_HZ), .SS_MAX_HZ(SS_MAX_HZ),
    .DS_MIN_HZ(DS_MIN_HZ), .DS_MAX_HZ(DS_MAX_HZ),
    .QS_MIN_HZ(QS_MIN_HZ), .QS_MAX_HZ(QS_MAX_HZ)
  ) u_class (
    .period_i(meas_per), .mode_o(cls)
  );

  // Qualification over consecutive frames
  spd_mode_e          mode_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               have_prev_q, valid_q, lock_q;
  logic [RUN_W-1:0]   run_q, run_nx;
  logic               same, valid_nx;

  always_comb begin
    same = have_prev_q && (cls == mode_q) && (meas_ratio == ratio_q);
    if (!same)                              run_nx = '0;
    else if (run_q != RUN_W'(STABLE_N - 1)) run_nx = run_q + 1'b1;
    else                                    run_nx = run_q;
    valid_nx = (run_nx == RUN_W'(STABLE_N - 1)) && (cls != MODE_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !all_present) begin
      mode_q      <= MODE_NONE;
      ratio_q     <= '0;
      have_prev_q <= 1'b0;
      run_q       <= '0;
      valid_q     <= 1'b0;
      lock_q      <= 1'b0;
    end else if (meas_stb) begin
      mode_q      <= cls;
      ratio_q     <= meas_ratio;
      have_prev_q <= 1'b1;
      run_q       <= run_nx;
      valid_q     <= valid_nx;
      lock_q      <= valid_nx && ratio_allowed(cls, 32'(meas_ratio));
    end
  end

  assign mode_o  = mode_q;
  assign ratio_o = ratio_q;
  assign valid_o = valid_q;
  assign lock_o  = lock_q;

  // R4: no valid report without a supported class
  a_r4_none_not_valid: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b00) |-> !valid_o);
  // R5: a missing clock clears every output on the next cycle
  a_r5_missing_clears: assert property (@(posedge clk) disable iff (rst)
    !all_present |=> (!valid_o && !lock_o && mode_o == 2'b00 && ratio_o == '0));
  // R7: lock implies qualification
  a_r7_lock_needs_valid: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> valid_o);
  // R9: while qualified, mode and ratio do not move
  a_r9_valid_holds: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o)) |-> ($stable(mode_o) && $stable(ratio_o)));

endmodule

// File: tb/spd_mode_detect_tb_top.sv
module spd_mode_detect_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        mst = 1'b0, bck = 1'b0, frm = 1'b0;
  logic [1:0]  mode;
  logic        valid, lock;
  logic [11:0] ratio;

  spd_mode_detect dut_i (
    .clk(clk), .rst(rst),
    .frm_clk_i(frm), .bit_clk_i(bck), .mst_clk_i(mst),
    .mode_o(mode), .valid_o(valid), .ratio_o(ratio), .lock_o(lock)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Stimulus model: master clock of period P reference cycles, frame period P*R.
  int P = 4, R = 512;
  int gen_id = 0, seen_id = 0;
  int mcnt = 0, fcnt = 0;
  bit mclk_en = 1'b1, bclk_en = 1'b1;

  always @(negedge clk) begin
    if (gen_id != seen_id) begin
      seen_id = gen_id; mcnt = 0; fcnt = 0;
    end else begin
      mcnt = (mcnt + 1) % P;
      fcnt = (fcnt + 1) % (P * R);
    end
    if (mclk_en) mst <= (mcnt < (P + 1) / 2);
    if (bclk_en && mcnt == 0) bck <= ~bck;
    frm <= (fcnt < (P * R) / 2);
  end

  // Invariants compared on every clock
  int inv_bad = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (valid && mode == 2'b00) inv_bad++;
      if (lock && !valid) inv_bad++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply one stimulus and compare the steady outputs to the expectation.
  task automatic run_case(string req, int p, int r, int emode, int elock);
    int T;
    int bm, bv, br, bl;
    T = p * r;
    @(negedge clk);
    P = p; R = r; gen_id++;
    wait_cyc(4 * T - 30);
    chk({req, " R8 not yet qualified"}, valid, 0);
    wait_cyc(3 * T + 30);
    bm = 0; bv = 0; br = 0; bl = 0;
    for (int k = 0; k < T; k++) begin
      @(negedge clk);
      if (mode != emode) bm++;
      if (valid != (emode != 0)) bv++;
      if (ratio != r) br++;
      if (lock != elock) bl++;
    end
    chk({req, " mode mismatch cycles"}, bm, 0);
    chk({req, " R8 valid mismatch cycles"}, bv, 0);
    chk({req, " R6 ratio mismatch cycles"}, br, 0);
    chk({req, " R7 lock mismatch cycles"}, bl, 0);
  endtask

  initial begin
    wait_cyc(5);
    @(negedge clk) rst = 1'b0;
    wait_cyc(3);
    // R11 reset state
    chk("R11 mode", mode, 0);
    chk("R11 valid", valid, 0);
    chk("R11 lock", lock, 0);
    chk("R11 ratio", ratio, 0);

    run_case("R1 single 512x", 4, 512, 1, 1);
    run_case("R9 single 1024x same period", 2, 1024, 1, 1);
    run_case("R1 single 600x disallowed", 4, 600, 1, 0);
    run_case("R2 double 256x", 4, 256, 2, 1);
    run_case("R2 double 512x", 2, 512, 2, 1);
    run_case("R3 quad 256x", 2, 256, 3, 1);
    run_case("R3 quad 192x", 3, 192, 3, 1);
    run_case("R3 quad 250x disallowed", 2, 250, 3, 0);

    // R5: stop the bit clock
    @(negedge clk) bclk_en = 1'b0;
    wait_cyc(150);
    chk("R5 bit missing mode", mode, 0);
    chk("R5 bit missing valid", valid, 0);
    chk("R5 bit missing lock", lock, 0);
    chk("R5 bit missing ratio", ratio, 0);
    @(negedge clk) bclk_en = 1'b1;

    run_case("R4 gap 700", 2, 350, 0, 0);
    run_case("R4 below windows 200", 2, 100, 0, 0);
    run_case("R10 lower edge 1820", 2, 910, 1, 0);
    run_case("R10 below tolerance 1818", 2, 909, 0, 0);

    // R5: stop the master clock after qualifying again
    run_case("R2 double 256x again", 4, 256, 2, 1);
    @(negedge clk) mclk_en = 1'b0;
    wait_cyc(150);
    chk("R5 master missing mode", mode, 0);
    chk("R5 master missing valid", valid, 0);
    chk("R5 master missing lock", lock, 0);
    @(negedge clk) mclk_en = 1'b1;

    chk("R4 R7 per-clock invariant violations", inv_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule